// File: doc/BRIEF.md
# DS3 Transmit Frame Timing Generator

This block sets the bit and overhead timing of outgoing DS3 M-frames. It runs on the 44.736 MHz transmit bit clock. A frame is seven subframes of eight blocks each, and every block is 85 bits long, so a frame is 4760 bits. The first bit of every block is an overhead slot, which gives 56 overhead slots per frame. The block reports where it is in the frame as three values: the bit position, the subframe index and the block index. It also gives two strobes: one marks an overhead slot and one marks the start of a frame.

Frame timing comes from one of two sources. In free-running mode the internal counter alone sets the frame boundaries. In reference mode, a rising edge on the frame-reference input forces the next frame to begin at bit 0. That input is synchronous to the bit clock and arrives at about the frame rate. Between edges the counter keeps running.

The line stage has two modes. In unipolar mode, one rail carries data and the other rail gives a one-bit end-of-frame marker. In bipolar mode, the two rails pass through as dual-rail pulse commands, and a high on the negative rail requests a negative pulse. The line clock output selects either the receive line clock or the transmit bit clock.

Top module: `ds3TxTiming`

## Requirements
- R1: While `rstN` is low, `bitIdx`, `subIdx` and `blkIdx` are 0 and `sofStb` is 1. After reset is released, the first bit shown is bit 0.
- R2: Unless a reference reload occurs, `bitIdx` advances by one every clock. It wraps from FRAME_BITS-1 to 0. `sofStb` is 1 exactly when `bitIdx` is 0.
- R3: `bitIdx` equals `subIdx`*BLK_BITS*BLKS_PER_SUB + `blkIdx`*BLK_BITS + offset, where offset is below BLK_BITS. `ohStb` is 1 exactly when offset is 0.
- R4: With `refMode`=1, suppose `frameRef` is sampled low at clock edge k-1 and high at edge k. Then `bitIdx` is 0 after edge k+1, and `sofStb` is 1 in that cycle.
- R5: In reference mode, the counter keeps counting and wrapping as in R2 between reference edges.
- R6: A reference held high reloads the counter only once. Only a new low-to-high transition reloads it again.
- R7: With `refMode`=0, `frameRef` has no effect on any output.
- R8: With `bipolar`=0, `txPos` follows `txData`. `txNeg` is 1 exactly when `bitIdx` equals FRAME_BITS-1.
- R9: With `bipolar`=1, `txPos` follows `posCmd` and `txNeg` follows `negCmd`.
- R10: `txLineClk` follows `rxLineClk` when `lineClkSel`=1 and follows `clk` when `lineClkSel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| refMode | input | 1 | 1 = align frames to the frame-reference input |
| frameRef | input | 1 | Frame-reference input, synchronous to `clk`, tied low when unused |
| bipolar | input | 1 | 1 = dual-rail line mode, 0 = unipolar |
| txData | input | 1 | Unipolar line data |
| posCmd | input | 1 | Bipolar positive pulse command |
| negCmd | input | 1 | Bipolar negative pulse command |
| rxLineClk | input | 1 | Receive line clock, an alternative line clock source |
| lineClkSel | input | 1 | 1 = line clock from `rxLineClk` |
| bitIdx | output | $clog2(FRAME_BITS) | Bit position in the frame |
| subIdx | output | SUB_W | Subframe index |
| blkIdx | output | BLK_W | Block index in the subframe |
| ohStb | output | 1 | Overhead slot strobe |
| sofStb | output | 1 | Start-of-frame strobe |
| txPos | output | 1 | Positive rail or unipolar data |
| txNeg | output | 1 | Negative rail or end-of-frame marker |
| txLineClk | output | 1 | Line clock output |

## Verification
The bench sweeps every bit position of several reduced-size frames. At each position it checks the block and subframe boundaries and the wrap point. A design with an off-by-one carry would place overhead strobes or the end-of-frame marker one bit early or late.

Reference edges are raised at mid-frame positions and then held high across a wrap. A detector that triggers on level rather than on the edge would pin the counter at 0. Wrong reload latency would show up as a nonzero bit position two clocks after the edge.

A reference pulse is also applied in free-running mode, where a missing mode gate would cause a reload. Finally, the bench runs the bipolar command combinations and both line-clock sources.

// File: rtl/ds3TxPkg.sv
package ds3TxPkg;
  typedef struct packed {
    logic sof;
    logic eof;
    logic ohSlot;
  } frameStrobes_t;
endpackage

// File: rtl/ds3TxCtrl.sv
module ds3TxCtrl import ds3TxPkg::*; #(
  parameter int BLK_BITS = 85,
  parameter int BLKS_PER_SUB = 8,
  parameter int SUBS_PER_FRAME = 7,
  localparam int FRAME_BITS = BLK_BITS * BLKS_PER_SUB * SUBS_PER_FRAME,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int OFS_W = (BLK_BITS > 1) ? $clog2(BLK_BITS) : 1,
  localparam int BLK_W = (BLKS_PER_SUB > 1) ? $clog2(BLKS_PER_SUB) : 1,
  localparam int SUB_W = (SUBS_PER_FRAME > 1) ? $clog2(SUBS_PER_FRAME) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refMode,
  input  logic             frameRef,
  output logic [CNT_W-1:0] bitCnt,
  output logic [SUB_W-1:0] subCnt,
  output logic [BLK_W-1:0] blkCnt,
  output frameStrobes_t    stb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BLK_BITS - 1);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLKS_PER_SUB - 1);
  localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(SUBS_PER_FRAME - 1);

  logic [OFS_W-1:0] ofsCnt;
  logic refQ, refPrev, refEdge, reload, frameEnd;

  assign refEdge  = refQ & ~refPrev;
  assign reload   = refMode & refEdge;
  assign frameEnd = (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ    <= 1'b0;
      refPrev <= 1'b0;
    end else begin
      refQ    <= frameRef;
      refPrev <= refQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || reload || frameEnd) begin
      bitCnt <= '0;
      ofsCnt <= '0;
      blkCnt <= '0;
      subCnt <= '0;
    end else begin
      bitCnt <= bitCnt + 1'b1;
      if (ofsCnt == LAST_OFS) begin
        ofsCnt <= '0;
        if (blkCnt == LAST_BLK) begin
          blkCnt <= '0;
          subCnt <= subCnt + 1'b1;
        end else begin
          blkCnt <= blkCnt + 1'b1;
        end
      end else begin
        ofsCnt <= ofsCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.sof    = (bitCnt == '0);
    stb.eof    = frameEnd;
    stb.ohSlot = (ofsCnt == '0);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!reload && bitCnt != LAST_BIT) |=> bitCnt == $past(bitCnt) + 1'b1); // R2
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == LAST_BIT) |=> (bitCnt == '0 && subCnt == '0 && blkCnt == '0)); // R2
  AST_REF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> (bitCnt == '0 && subCnt == '0 && blkCnt == '0)); // R4
  AST_FREE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!refMode && bitCnt != LAST_BIT) |=> bitCnt != '0); // R7
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= LAST_SUB); // R3
  AST_BLK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    blkCnt <= LAST_BLK); // R3
endmodule

// File: rtl/ds3TxLine.sv
module ds3TxLine import ds3TxPkg::*; (
  input  logic          clk,
  input  logic          rstN,
  input  frameStrobes_t stb,
  input  logic          bipolar,
  input  logic          txData,
  input  logic          posCmd,
  input  logic          negCmd,
  input  logic          rxLineClk,
  input  logic          lineClkSel,
  output logic          txPos,
  output logic          txNeg,
  output logic          txLineClk
);
  always_comb begin
    if (bipolar) begin
      txPos = posCmd;
      txNeg = negCmd;
    end else begin
      txPos = txData;
      txNeg = stb.eof;
    end
  end

  assign txLineClk = lineClkSel ? rxLineClk : clk;

  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (!bipolar && txNeg) |=> (bipolar || !txNeg)); // R8
  AST_EOF_THEN_SOF: assert property (@(posedge clk) disable iff (!rstN)
    (!bipolar && txNeg) |=> stb.sof); // R8
endmodule

// File: rtl/ds3TxTiming.sv
module ds3TxTiming import ds3TxPkg::*; #(
  parameter int BLK_BITS = 85,
  parameter int BLKS_PER_SUB = 8,
  parameter int SUBS_PER_FRAME = 7,
  localparam int FRAME_BITS = BLK_BITS * BLKS_PER_SUB * SUBS_PER_FRAME,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int BLK_W = (BLKS_PER_SUB > 1) ? $clog2(BLKS_PER_SUB) : 1,
  localparam int SUB_W = (SUBS_PER_FRAME > 1) ? $clog2(SUBS_PER_FRAME) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refMode,
  input  logic             frameRef,
  input  logic             bipolar,
  input  logic             txData,
  input  logic             posCmd,
  input  logic             negCmd,
  input  logic             rxLineClk,
  input  logic             lineClkSel,
  output logic [CNT_W-1:0] bitIdx,
  output logic [SUB_W-1:0] subIdx,
  output logic [BLK_W-1:0] blkIdx,
  output logic             ohStb,
  output logic             sofStb,
  output logic             txPos,
  output logic             txNeg,
  output logic             txLineClk
);
  frameStrobes_t stb;

  ds3TxCtrl #(
    .BLK_BITS(BLK_BITS),
    .BLKS_PER_SUB(BLKS_PER_SUB),
    .SUBS_PER_FRAME(SUBS_PER_FRAME)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .refMode(refMode), .frameRef(frameRef),
    .bitCnt(bitIdx), .subCnt(subIdx), .blkCnt(blkIdx), .stb(stb)
  );

  ds3TxLine i_line (
    .clk(clk), .rstN(rstN), .stb(stb), .bipolar(bipolar), .txData(txData),
    .posCmd(posCmd), .negCmd(negCmd), .rxLineClk(rxLineClk),
    .lineClkSel(lineClkSel), .txPos(txPos), .txNeg(txNeg), .txLineClk(txLineClk)
  );

  assign ohStb  = stb.ohSlot;
  assign sofStb = stb.sof;
endmodule

// File: tb/test_ds3TxTiming.sv
module test_ds3TxTiming;
  localparam int BB = 5;
  localparam int BS = 3;
  localparam int SF = 2;
  localparam int FB = BB * BS * SF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refMode = 1'b0, frameRef = 1'b0, bipolar = 1'b0, txData = 1'b0;
  logic posCmd = 1'b0, negCmd = 1'b0, rxLineClk = 1'b0, lineClkSel = 1'b0;
  logic [$clog2(FB)-1:0] bitIdx;
  logic subIdx;
  logic [1:0] blkIdx;
  logic ohStb, sofStb, txPos, txNeg, txLineClk;

  int checks = 0;
  int failures = 0;
  int expCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ds3TxTiming #(.BLK_BITS(BB), .BLKS_PER_SUB(BS), .SUBS_PER_FRAME(SF)) i_ds3TxTiming (
    .clk(clk), .rstN(rstN), .refMode(refMode), .frameRef(frameRef),
    .bipolar(bipolar), .txData(txData), .posCmd(posCmd), .negCmd(negCmd),
    .rxLineClk(rxLineClk), .lineClkSel(lineClkSel), .bitIdx(bitIdx),
    .subIdx(subIdx), .blkIdx(blkIdx), .ohStb(ohStb), .sofStb(sofStb),
    .txPos(txPos), .txNeg(txNeg), .txLineClk(txLineClk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one clock; expected counter follows R2 unless overridden
  task automatic tick();
    @(negedge clk);
    #1;
    expCnt = (expCnt + 1) % FB;
  endtask

  task automatic checkPos(input string req);
    check({req, " bitIdx"}, int'(bitIdx), expCnt);
    check({req, " R3 subIdx"}, int'(subIdx), expCnt / (BB * BS));
    check({req, " R3 blkIdx"}, int'(blkIdx), (expCnt % (BB * BS)) / BB);
    check({req, " R3 ohStb"}, int'(ohStb), int'(expCnt % BB == 0));
    check({req, " R2 sofStb"}, int'(sofStb), int'(expCnt == 0));
    if (!bipolar)
      check({req, " R8 txNeg"}, int'(txNeg), int'(expCnt == FB - 1));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    expCnt = 0;
    checkPos("R1 reset");
    rstN = 1'b1;
    checkPos("R1 first");

    // R2/R3/R8 sweep over three frames, unipolar, free-running
    for (int n = 0; n < 3 * FB; n++) begin
      txData = n[0];
      #1;
      check("R8 txPos", int'(txPos), n % 2);
      tick();
      checkPos("R2 sweep");
    end

    // R7: reference pulse ignored when free-running
    refMode = 1'b0;
    frameRef = 1'b1;
    for (int n = 0; n < 4; n++) begin
      tick();
      checkPos("R7 ignored");
    end
    frameRef = 1'b0;
    for (int n = 0; n < 3; n++) tick();
    checkPos("R7 after");

    // R4: reference edge mid-frame
    refMode = 1'b1;
    while (expCnt != 7) tick();
    frameRef = 1'b1;
    tick();
    checkPos("R4 before reload");
    tick();
    expCnt = 0;
    checkPos("R4 reload");
    // R5/R6: held high, keeps counting through a wrap
    for (int n = 0; n < FB + 6; n++) begin
      tick();
      checkPos("R6 held");
    end
    frameRef = 1'b0;
    tick();
    tick();
    checkPos("R5 low");
    frameRef = 1'b1;
    tick();
    tick();
    expCnt = 0;
    checkPos("R4 second edge");
    frameRef = 1'b0;
    for (int n = 0; n < FB; n++) begin
      tick();
      checkPos("R5 running");
    end

    // R9: bipolar pass-through
    bipolar = 1'b1;
    for (int v = 0; v < 4; v++) begin
      posCmd = v[0];
      negCmd = v[1];
      #1;
      check("R9 txPos", int'(txPos), v % 2);
      check("R9 txNeg", int'(txNeg), v / 2);
      tick();
    end

    // R10: line clock source
    lineClkSel = 1'b1;
    rxLineClk = 1'b1;
    #1;
    check("R10 rx high", int'(txLineClk), 1);
    rxLineClk = 1'b0;
    #1;
    check("R10 rx low", int'(txLineClk), 0);
    lineClkSel = 1'b0;
    rxLineClk = 1'b1;
    #1;
    check("R10 tx low", int'(txLineClk), int'(clk));
    @(posedge clk);
    #1;
    check("R10 tx high", int'(txLineClk), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule